// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command pins from reset until the memory can accept normal traffic. Throughout that time it keeps clock enable and every data mask high. It first presents no-operation commands for a stabilisation interval, which is set as a clock rate in MHz times a duration in microseconds. It then closes all banks with a single precharge. Next it runs a group of auto-refresh commands and loads the mode register. A captured configuration bit decides which of those two steps comes first. Each command is followed by its own recovery gap of no-operation cycles.

The mode register word is assembled from four configuration inputs: burst length, burst type, CAS latency and single-write mode. The block checks these inputs for reserved codes. If the captured settings are legal, a ready flag rises once the last recovery gap has ended, and the command bus then belongs to the downstream controller. If the settings are reserved, the block raises an error flag instead, issues no command at all, and never signals ready.

All configuration inputs are sampled on every clock edge while reset is low. They are ignored once reset is released.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low, and for STABLE_CYCLES = CLK_MHZ*STABLE_US cycles after it is released, the command pins present NOP. CKE and all DQM bits are high at all times.
- R2: The first command is precharge-all. It appears in cycle STABLE_CYCLES after release (cycle 1 being the first cycle after the releasing edge), with address bit 10 set, all other address bits 0 and bank address 0.
- R3: Exactly REFRESH_COUNT auto-refresh commands (at least 2) are issued. Each one is followed by T_RC NOP cycles.
- R4: The mode-set address word is built as follows: bits 2:0 are the burst length code, bit 3 is the burst type (1 = interleaved), bits 6:4 are the CAS latency code, and bit 9 is the single-write flag. Bits 8:7, bit 10, all bits above 10 and the bank address are 0.
- R5: With the order bit 0, the refresh group runs before the mode set. With the order bit 1, the mode set comes directly after the precharge gap and the refresh group follows it.
- R6: Precharge is followed by T_RP NOP cycles and mode set by T_MRD NOP cycles before the next command.
- R7: Ready rises in the cycle after the final recovery gap ends and stays high until reset. Every cycle that is not a command slot presents NOP.
- R8: Burst length codes 3'b100 to 3'b110 and CAS latency codes other than 3'b010 and 3'b011 are illegal. With an illegal code, the error flag rises in cycle STABLE_CYCLES, no command other than NOP is ever issued, and ready stays low.
- R9: Full-page burst (code 3'b111) is legal with sequential type and illegal with interleaved type.
- R10: The configuration is captured on every clock edge while reset is low. Changes made after release have no effect on the command sequence or on the mode word.

Command encoding on (CS_n, RAS_n, CAS_n, WE_n) is as follows:

| Command | CS_n | RAS_n | CAS_n | WE_n |
|---|---|---|---|---|
| NOP | 0 | 1 | 1 | 1 |
| precharge | 0 | 0 | 1 | 0 |
| auto-refresh | 0 | 0 | 0 | 1 |
| mode set | 0 | 0 | 0 | 0 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_burst_type | input | 1 | 0 sequential, 1 interleaved |
| cfg_cas_lat | input | 3 | CAS latency code |
| cfg_single_write | input | 1 | Single-location write bursts |
| cfg_mode_first | input | 1 | 1: mode set before the refresh group |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | DQM_W | Data masks |
| sd_addr | output | ADDR_W | Address bus |
| sd_ba | output | BA_W | Bank address |
| init_done | output | 1 | Sequence complete, bus handed over |
| cfg_error | output | 1 | Reserved configuration code detected |

## Verification
Two events can coincide. The configuration can change in the same cycle that reset is released. Separately, the legality decision is taken on the same edge that the stabilisation timer expires. To provoke the first, the bench inverts every configuration field in the very cycle it releases reset. It then judges that the mode word, the refresh/mode-set order and the error outcome all follow the values held before release. To provoke the second, the sweep covers every burst-length, burst-type, CAS-latency and order combination. It checks that either the precharge or the error flag appears exactly in cycle STABLE_CYCLES, never both and never neither.

// File: rtl/sdram_init_pkg.sv
// Shared types for the SDRAM initialization sequencer.
// Assumes a single clock domain; the enums are internal only.
package sdram_init_pkg;

    typedef enum logic [2:0] {
        ST_STABLE,
        ST_PRE,
        ST_REF,
        ST_MRS,
        ST_WAIT,
        ST_READY,
        ST_HALT
    } seq_state_t;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRE,
        CMD_REF,
        CMD_MRS
    } sd_cmd_t;

    typedef struct packed {
        logic [2:0] burst_len;
        logic       burst_type;
        logic [2:0] cas_lat;
        logic       single_write;
        logic       mode_first;
    } init_cfg_t;

    localparam logic [2:0] BL_FULL_PAGE = 3'b111;

endpackage

// File: rtl/init_mode_word.sv
// Builds the mode-register address word from a captured configuration
// and flags reserved codes. Purely combinational.
// Assumes ADDR_W >= 11; bits above 9 are always zero.
module init_mode_word
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  init_cfg_t         cfg,
    output logic [ADDR_W-1:0] word,
    output logic              legal
);

    logic bl_ok;
    logic cas_ok;

    // Assemble the address word field by field.
    always_comb begin
        word      = '0;
        word[2:0] = cfg.burst_len;
        word[3]   = cfg.burst_type;
        word[6:4] = cfg.cas_lat;
        word[8:7] = 2'b00;
        word[9]   = cfg.single_write;
    end

    // Legality of the burst length and CAS latency codes.
    always_comb begin
        unique case (cfg.burst_len)
            3'b000, 3'b001, 3'b010, 3'b011: bl_ok = 1'b1;
            BL_FULL_PAGE:                   bl_ok = ~cfg.burst_type;
            default:                        bl_ok = 1'b0;
        endcase
        cas_ok = (cfg.cas_lat == 3'b010) || (cfg.cas_lat == 3'b011);
        legal  = bl_ok && cas_ok;
    end

endmodule

// File: rtl/init_wait_timer.sv
// Down-counter shared by every wait in the sequence.
// Reset preloads RESET_VAL (the stabilisation wait); a load sets a new
// value. expired is high while the count is zero.
// Assumes RESET_VAL fits in CNT_W bits.
module init_wait_timer #(
    parameter int CNT_W     = 16,
    parameter int RESET_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count down to zero, reloading on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RESET_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/init_cmd_encode.sv
// Maps an abstract command to SDRAM pin levels.
// Clock enable and data masks are held high for the whole
// initialization; precharge uses the all-banks address bit.
module init_cmd_encode
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int BA_W   = 2,
    parameter int DQM_W  = 4
) (
    input  sd_cmd_t           cmd,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              cke,
    output logic [DQM_W-1:0]  dqm,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);

    localparam int ALL_BANKS_BIT = 10;

    // Strobe levels and address for the current command.
    always_comb begin
        cs_n  = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        addr  = '0;
        unique case (cmd)
            CMD_PRE: begin
                ras_n               = 1'b0;
                we_n                = 1'b0;
                addr[ALL_BANKS_BIT] = 1'b1;
            end
            CMD_REF: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            CMD_MRS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                addr  = mode_word;
            end
            default: ;
        endcase
    end

    // One generated driver per mask bit, all held high.
    for (genvar g = 0; g < DQM_W; g++) begin : g_dqm
        assign dqm[g] = 1'b1;
    end

    assign cke = 1'b1;
    assign ba  = '0;

endmodule

// File: rtl/sdram_init_seq.sv
// SDRAM power-up initialization sequencer (top).
// Captures the configuration while reset is low, waits the stabilisation
// interval with NOPs, then issues precharge-all, the refresh group and the
// mode set in the captured order, each followed by its recovery gap.
// Assumes T_RP, T_RC, T_MRD >= 1 and REFRESH_COUNT >= 2.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ       = 125,
    parameter int STABLE_US     = 200,
    parameter int T_RP          = 3,
    parameter int T_RC          = 9,
    parameter int T_MRD         = 2,
    parameter int REFRESH_COUNT = 2,
    parameter int ADDR_W        = 11,
    parameter int BA_W          = 2,
    parameter int DQM_W         = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_type,
    input  logic [2:0]        cfg_cas_lat,
    input  logic              cfg_single_write,
    input  logic              cfg_mode_first,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic              sd_cke,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba,
    output logic              init_done,
    output logic              cfg_error
);

    localparam int STABLE_CYCLES = CLK_MHZ * STABLE_US;
    localparam int MAX_GAP_A     = (T_RP > T_RC) ? T_RP : T_RC;
    localparam int MAX_GAP_B     = (MAX_GAP_A > T_MRD) ? MAX_GAP_A : T_MRD;
    localparam int MAX_WAIT      = (MAX_GAP_B > STABLE_CYCLES) ? MAX_GAP_B : STABLE_CYCLES;
    localparam int CNT_W         = $clog2(MAX_WAIT + 1);
    localparam int RC_W          = $clog2(REFRESH_COUNT + 1);

    localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] RC_LOAD  = CNT_W'(T_RC - 1);
    localparam logic [CNT_W-1:0] MRD_LOAD = CNT_W'(T_MRD - 1);

    init_cfg_t         cfg_q;
    seq_state_t        state_q, state_d;
    logic [RC_W-1:0]   refs_left_q;
    logic              mrs_done_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic [ADDR_W-1:0] mode_word;
    logic              cfg_legal;
    logic              refs_done;
    sd_cmd_t           cmd;

    // Capture the configuration while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{burst_len:    cfg_burst_len,
                       burst_type:   cfg_burst_type,
                       cas_lat:      cfg_cas_lat,
                       single_write: cfg_single_write,
                       mode_first:   cfg_mode_first};
        end
    end

    init_mode_word #(.ADDR_W(ADDR_W)) u_word (
        .cfg   (cfg_q),
        .word  (mode_word),
        .legal (cfg_legal)
    );

    init_wait_timer #(.CNT_W(CNT_W), .RESET_VAL(STABLE_CYCLES - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    assign refs_done = (refs_left_q == '0);

    // Next-state choice and wait-timer loading.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_STABLE: begin
                if (tmr_expired) state_d = cfg_legal ? ST_PRE : ST_HALT;
            end
            ST_PRE: begin
                tmr_load = 1'b1;
                tmr_val  = RP_LOAD;
                state_d  = ST_WAIT;
            end
            ST_REF: begin
                tmr_load = 1'b1;
                tmr_val  = RC_LOAD;
                state_d  = ST_WAIT;
            end
            ST_MRS: begin
                tmr_load = 1'b1;
                tmr_val  = MRD_LOAD;
                state_d  = ST_WAIT;
            end
            ST_WAIT: begin
                if (tmr_expired) begin
                    if (!refs_done && (!cfg_q.mode_first || mrs_done_q)) begin
                        state_d = ST_REF;
                    end else if (!mrs_done_q) begin
                        state_d = ST_MRS;
                    end else begin
                        state_d = ST_READY;
                    end
                end
            end
            default: state_d = state_q;
        endcase
    end

    // State, refresh budget and mode-set bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_STABLE;
            refs_left_q <= RC_W'(REFRESH_COUNT);
            mrs_done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_REF) refs_left_q <= refs_left_q - 1'b1;
            if (state_q == ST_MRS) mrs_done_q  <= 1'b1;
        end
    end

    // Command slot for the current state.
    always_comb begin
        unique case (state_q)
            ST_PRE:  cmd = CMD_PRE;
            ST_REF:  cmd = CMD_REF;
            ST_MRS:  cmd = CMD_MRS;
            default: cmd = CMD_NOP;
        endcase
    end

    init_cmd_encode #(.ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W)) u_enc (
        .cmd       (cmd),
        .mode_word (mode_word),
        .cs_n      (sd_cs_n),
        .ras_n     (sd_ras_n),
        .cas_n     (sd_cas_n),
        .we_n      (sd_we_n),
        .cke       (sd_cke),
        .dqm       (sd_dqm),
        .addr      (sd_addr),
        .ba        (sd_ba)
    );

    assign init_done = (state_q == ST_READY);
    assign cfg_error = (state_q == ST_HALT);

endmodule

// File: rtl/sdram_init_chk.sv
// Protocol checker for the initialization sequencer, bound to the top.
// Observes pins only; counts refresh commands itself.
module sdram_init_chk #(
    parameter int REFRESH_COUNT = 2,
    parameter int ADDR_W        = 11,
    parameter int BA_W          = 2,
    parameter int DQM_W         = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic              sd_cke,
    input logic [DQM_W-1:0]  sd_dqm,
    input logic [ADDR_W-1:0] sd_addr,
    input logic [BA_W-1:0]   sd_ba,
    input logic              init_done,
    input logic              cfg_error
);

    localparam int SEEN_W = $clog2(REFRESH_COUNT + 2);

    logic [3:0] pins;
    logic       is_nop, is_pre, is_ref, is_mrs;
    logic [SEEN_W-1:0] ref_seen;

    assign pins   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_nop = (pins == 4'b0111);
    assign is_pre = (pins == 4'b0010);
    assign is_ref = (pins == 4'b0001);
    assign is_mrs = (pins == 4'b0000);

    // Count refresh commands seen since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_seen <= '0;
        else if (is_ref) ref_seen <= ref_seen + 1'b1;
    end

    // R1
    pins_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cke && (&sd_dqm));

    // R2
    pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (sd_addr[10] && sd_ba == '0));

    // R3
    ref_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (ref_seen < SEEN_W'(REFRESH_COUNT)));

    // R4
    mrs_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (sd_addr[8:7] == 2'b00 && sd_addr[ADDR_W-1:10] == '0 && sd_ba == '0));

    // R6
    gap_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_nop |=> is_nop);

    // R7
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R7
    ready_refs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (ref_seen == SEEN_W'(REFRESH_COUNT) && is_nop));

    // R8
    error_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |-> (is_nop && !init_done));

endmodule

bind sdram_init_seq sdram_init_chk #(
    .REFRESH_COUNT (REFRESH_COUNT),
    .ADDR_W        (ADDR_W),
    .BA_W          (BA_W),
    .DQM_W         (DQM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_cke    (sd_cke),
    .sd_dqm    (sd_dqm),
    .sd_addr   (sd_addr),
    .sd_ba     (sd_ba),
    .init_done (init_done),
    .cfg_error (cfg_error)
);

// File: tb/sim_sdram_init_seq.sv
// Sweeps every burst length, burst type, CAS latency and order setting
// through full initialization runs and compares each cycle with a
// schedule computed from the requirements.
module sim_sdram_init_seq;

    localparam int S      = 12;
    localparam int TRP    = 2;
    localparam int TRC    = 3;
    localparam int TMRD   = 2;
    localparam int NREF   = 3;
    localparam int AW     = 12;
    localparam int BW     = 2;
    localparam int DW     = 4;
    localparam int MAXN   = S + 1 + TRP + 1 + TMRD + NREF * (1 + TRC) + 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [2:0]    cfg_bl = '0;
    logic          cfg_bt = 1'b0;
    logic [2:0]    cfg_cas = '0;
    logic          cfg_sw = 1'b0;
    logic          cfg_mf = 1'b0;
    logic          cs_n, ras_n, cas_n, we_n, cke;
    logic [DW-1:0] dqm;
    logic [AW-1:0] addr;
    logic [BW-1:0] ba;
    logic          done, err;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    int    exp_kind [0:MAXN];
    string exp_req  [0:MAXN];

    sdram_init_seq #(
        .CLK_MHZ(1), .STABLE_US(S), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD),
        .REFRESH_COUNT(NREF), .ADDR_W(AW), .BA_W(BW), .DQM_W(DW)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_burst_len(cfg_bl), .cfg_burst_type(cfg_bt), .cfg_cas_lat(cfg_cas),
        .cfg_single_write(cfg_sw), .cfg_mode_first(cfg_mf),
        .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
        .sd_cke(cke), .sd_dqm(dqm), .sd_addr(addr), .sd_ba(ba),
        .init_done(done), .cfg_error(err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // 0 NOP, 1 precharge, 2 refresh, 3 mode set, 7 anything else
    function automatic int pin_kind();
        case ({cs_n, ras_n, cas_n, we_n})
            4'b0111: return 0;
            4'b0010: return 1;
            4'b0001: return 2;
            4'b0000: return 3;
            default: return 7;
        endcase
    endfunction

    // Place one command and its NOP gap into the expected schedule.
    task automatic put(inout int p, input int kind, input string req,
                       input int gap, input string gap_req);
        exp_kind[p] = kind;
        exp_req[p]  = req;
        for (int i = 1; i <= gap; i++) exp_req[p + i] = gap_req;
        p = p + 1 + gap;
    endtask

    task automatic run_one(input logic [2:0] bl, input bit bt,
                           input logic [2:0] cas, input bit sw, input bit mf);
        bit            legal;
        int            p;
        int            ready_at;
        logic [AW-1:0] ew;
        string         lreq;

        @(negedge clk);
        rst_n   = 1'b0;
        cfg_bl  = bl;
        cfg_bt  = bt;
        cfg_cas = cas;
        cfg_sw  = sw;
        cfg_mf  = mf;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(pin_kind() == 0, "R1", "reset cmd", pin_kind(), 0);
        check(cke && (&dqm), "R1", "reset cke/dqm", {cke, dqm}, {1'b1, {DW{1'b1}}});
        check(!done && !err, "R1", "reset flags", {done, err}, 0);

        legal = ((bl <= 3'd3) || (bl == 3'd7 && !bt)) && (cas == 3'd2 || cas == 3'd3);
        lreq  = (bl == 3'd7) ? "R9" : "R8";
        ew = '0;
        ew[2:0] = bl;
        ew[3]   = bt;
        ew[6:4] = cas;
        ew[9]   = sw;
        for (int n = 0; n <= MAXN; n++) begin
            exp_kind[n] = 0;
            exp_req[n]  = (n < S) ? "R1" : "R7";
        end
        ready_at = MAXN + 100;
        if (legal) begin
            p = S;
            put(p, 1, "R2", TRP, "R6");
            if (mf) put(p, 3, "R5", TMRD, "R6");
            for (int r = 0; r < NREF; r++) put(p, 2, "R3", TRC, "R3");
            if (!mf) put(p, 3, "R5", TMRD, "R6");
            ready_at = p;
        end

        // Release reset and disturb every configuration input at once.
        rst_n   = 1'b1;
        cfg_bl  = ~bl;
        cfg_bt  = ~bt;
        cfg_cas = ~cas;
        cfg_sw  = ~sw;
        cfg_mf  = ~mf;

        for (int n = 1; n <= MAXN; n++) begin
            @(posedge clk);
            @(negedge clk);
            check(pin_kind() == exp_kind[n], exp_req[n], $sformatf("cmd at cycle %0d", n),
                  pin_kind(), exp_kind[n]);
            check(cke && (&dqm), "R1", "cke/dqm", {cke, dqm}, {1'b1, {DW{1'b1}}});
            if (exp_kind[n] == 1) begin
                check(addr == (AW'(1) << 10) && ba == '0, "R2", "precharge addr",
                      {ba, addr}, AW'(1) << 10);
            end
            if (exp_kind[n] == 3) begin
                check(addr == ew && ba == '0, "R4 R10", "mode word", {ba, addr}, ew);
            end
            check(done == (legal && n >= ready_at), "R7", $sformatf("ready at cycle %0d", n),
                  done, legal && n >= ready_at);
            check(err == (!legal && n >= S), lreq, $sformatf("error at cycle %0d", n),
                  err, !legal && n >= S);
        end
    endtask

    initial begin
        for (int b = 0; b < 8; b++) begin
            for (int t = 0; t < 2; t++) begin
                for (int c = 0; c < 8; c++) begin
                    for (int m = 0; m < 2; m++) begin
                        run_one(3'(b), t[0], 3'(c), b[0] ^ c[0], m[0]);
                    end
                end
            end
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R7 watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule